// File: doc/BRIEF.md
# Countdown Event Timer

This block is a one-shot event timer held in two 32-bit registers. Software stops the timer, loads a tick count, then turns on counting and the interrupt. The count drops by one on every tick-enable pulse. When it reaches zero it stops there and raises a sticky pending flag. The interrupt line is the pending flag gated by both the run bit and the interrupt-enable bit.

Software acknowledges an event by writing the clear bit together with the run bit. This drops the pending flag and leaves the timer running with its interrupt masked, ready to be armed again. Writing zero to the control register stops the count and masks the interrupt. Writing the count register at any time restarts the countdown from the new value.

Top module: `evt_timer`

## Requirements
- R1: After reset the run bit, the interrupt-enable bit, the pending flag and the count are all 0, `irq` is 0, and both registers read 0.
- R2: The control register is at byte offset 0x40. Bit 0 is run and bit 1 is interrupt-enable, and both read back as written. Bit 4 is a write-only clear that always reads 0, and every other bit reads 0.
- R3: The count register is at byte offset 0x44. A write loads all 32 bits, and a read returns the live remaining count.
- R4: While run is 1 and the count is nonzero, each cycle with `tick_en` high lowers the count by exactly one. A cycle without `tick_en` leaves the count unchanged.
- R5: The tick that takes the count from 1 to 0 sets the pending flag. The count then stays at 0 under further ticks.
- R6: `irq` is high only when the pending flag, run and interrupt-enable are all 1. An event that expires while interrupts are masked becomes visible once interrupt-enable is set.
- R7: A control write with bit 4 set clears the pending flag, and run and interrupt-enable take the written values. If an expiry happens in the same cycle as that write, the flag ends up set.
- R8: Writing 0 to the control register freezes the count, forces `irq` low and keeps the pending flag.
- R9: A write to the count register restarts the countdown from the written value and leaves the pending flag as it was.
- R10: When a count write and a tick happen in the same cycle, the count takes the written value and no decrement occurs.
- R11: Writes to any other offset change no state, and reads from any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Single-cycle count enable from the tick generator |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset for both reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that a register write lasts exactly one cycle. They also assume that `tick_en` and the write strobe are sampled cleanly at the clock edge, so a write and a tick in the same cycle must be resolved by the stated priorities. The stimulus drives every input on the falling edge and holds it for exactly one cycle. Armed delays stay within the usable range of three ticks up to 0xFFFFFFFF. Only the collision scenario deliberately lets the count reach 1 before a clear is written in the same cycle as the final tick.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int TMR_W   = 32;
    localparam int RUN_BIT = 0;
    localparam int IE_BIT  = 1;
    localparam int CLR_BIT = 4;

    typedef struct packed {
        logic             run;
        logic             ie;
        logic             pend;
        logic [TMR_W-1:0] cnt;
    } tmr_state_t;

endpackage

// File: rtl/evt_timer_regdec.sv
module evt_timer_regdec
    import evt_timer_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter [ADDR_W-1:0] CTRL_OFS = 8'h40,
    parameter [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              run,
    input  logic              ie,
    input  logic [TMR_W-1:0]  cnt,
    output logic              ctrl_wr,
    output logic              val_wr,
    output logic [TMR_W-1:0]  rdata
);

    logic hit_ctrl;
    logic hit_val;

    assign hit_ctrl = (addr == CTRL_OFS);
    assign hit_val  = (addr == VAL_OFS);
    assign ctrl_wr  = wr_en && hit_ctrl;
    assign val_wr   = wr_en && hit_val;

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[RUN_BIT] = run;
            rdata[IE_BIT]  = ie;
        end else if (hit_val) begin
            rdata = cnt;
        end
    end

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ctrl_wr,
    input  logic             val_wr,
    input  logic [TMR_W-1:0] wdata,
    output logic             run,
    output logic             ie,
    output logic             pend,
    output logic [TMR_W-1:0] cnt
);

    tmr_state_t st_d, st_q;
    logic       step;
    logic       expire;

    always_comb begin
        st_d   = st_q;
        step   = st_q.run && tick_en && (st_q.cnt != '0) && !val_wr;
        expire = step && (st_q.cnt == TMR_W'(1));

        if (val_wr) begin
            st_d.cnt = wdata;
        end else if (step) begin
            st_d.cnt = st_q.cnt - TMR_W'(1);
        end

        if (ctrl_wr) begin
            st_d.run = wdata[RUN_BIT];
            st_d.ie  = wdata[IE_BIT];
            if (wdata[CLR_BIT]) begin
                st_d.pend = 1'b0;
            end
        end

        if (expire) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run  = st_q.run;
    assign ie   = st_q.ie;
    assign pend = st_q.pend;
    assign cnt  = st_q.cnt;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter [ADDR_W-1:0] CTRL_OFS = 8'h40,
    parameter [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TMR_W-1:0]  wdata,
    output logic [TMR_W-1:0]  rdata,
    output logic              irq
);

    logic             ctrl_wr;
    logic             val_wr;
    logic             run_w;
    logic             ie_w;
    logic             pend_w;
    logic [TMR_W-1:0] cnt_w;

    evt_timer_regdec #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS),
        .VAL_OFS (VAL_OFS)
    ) u_dec (
        .wr_en  (wr_en),
        .addr   (addr),
        .run    (run_w),
        .ie     (ie_w),
        .cnt    (cnt_w),
        .ctrl_wr(ctrl_wr),
        .val_wr (val_wr),
        .rdata  (rdata)
    );

    evt_timer_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .ctrl_wr(ctrl_wr),
        .val_wr (val_wr),
        .wdata  (wdata),
        .run    (run_w),
        .ie     (ie_w),
        .pend   (pend_w),
        .cnt    (cnt_w)
    );

    assign irq = pend_w && ie_w && run_w;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter [ADDR_W-1:0] CTRL_OFS = 8'h40,
    parameter [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [TMR_W-1:0]  wdata,
    input logic              irq,
    input logic              run,
    input logic              ie,
    input logic              pend,
    input logic [TMR_W-1:0]  cnt
);

    logic c_wr;
    logic v_wr;
    logic last_tick;

    assign c_wr      = wr_en && (addr == CTRL_OFS);
    assign v_wr      = wr_en && (addr == VAL_OFS);
    assign last_tick = run && tick_en && !v_wr && (cnt == TMR_W'(1));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !v_wr && cnt != '0) |=> (cnt == $past(cnt) - TMR_W'(1)));

    // R5
    expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_tick |=> (pend && cnt == '0));

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (run && ie && pend));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && wdata[CLR_BIT] && !last_tick) |=> !pend);

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !v_wr) |=> $stable(cnt));

    // R9
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(c_wr && wdata[CLR_BIT])) |=> pend);

    // R10
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_wr |=> (cnt == $past(wdata)));

endmodule

bind evt_timer evt_timer_chk #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .VAL_OFS (VAL_OFS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .irq    (irq),
    .run    (run_w),
    .ie     (ie_w),
    .pend   (pend_w),
    .cnt    (cnt_w)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;

    localparam int   CLK_PERIOD = 10;
    localparam [7:0] A_CTRL     = 8'h40;
    localparam [7:0] A_VAL      = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .irq    (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; tick_en = tk;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        rd(A_VAL, v);  check("R1 value", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_countdown();
        logic [31:0] v;
        wr(A_CTRL, 32'h1);
        wr(A_VAL, 32'd10);
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, v); check("R2 ctrl readback", v, 32'h3);
        rd(A_VAL, v);  check("R3 load", v, 32'd10);
        ticks(4);
        rd(A_VAL, v);  check("R4 after 4 ticks", v, 32'd6);
        idle(3);
        rd(A_VAL, v);  check("R4 no tick hold", v, 32'd6);
        ticks(5);
        rd(A_VAL, v);  check("R4 count 1", v, 32'd1);
        check("R6 irq before expiry", {31'b0, irq}, 32'h0);
        ticks(1);
        rd(A_VAL, v);  check("R5 reached zero", v, 32'd0);
        check("R5 irq at expiry", {31'b0, irq}, 32'h1);
        ticks(3);
        rd(A_VAL, v);  check("R5 stays zero", v, 32'd0);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        wr(A_CTRL, 32'h11);
        check("R7 ack drops irq", {31'b0, irq}, 32'h0);
        rd(A_CTRL, v); check("R2 clear bit reads 0", v, 32'h1);
        wr(A_CTRL, 32'h3);
        check("R7 pending gone", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'hFFFF_FFEC);
        rd(A_CTRL, v); check("R2 other bits read 0", v, 32'h0);
    endtask

    task automatic t_mask();
        wr(A_CTRL, 32'h1);
        wr(A_VAL, 32'd5);
        ticks(5);
        check("R6 masked expiry", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h3);
        check("R6 unmask shows event", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h0);
        check("R8 stop masks irq", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h3);
        check("R8 pending kept", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h11);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(A_CTRL, 32'h1);
        wr(A_VAL, 32'd20);
        wr(A_CTRL, 32'h3);
        ticks(5);
        wr(A_CTRL, 32'h0);
        ticks(5);
        rd(A_VAL, v); check("R8 frozen", v, 32'd15);
        wr(A_CTRL, 32'h3);
        ticks(2);
        rd(A_VAL, v); check("R8 resumes", v, 32'd13);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        wr(A_VAL, 32'd3);
        ticks(3);
        check("R9 expired", {31'b0, irq}, 32'h1);
        wr(A_VAL, 32'd8);
        check("R9 pending kept on reload", {31'b0, irq}, 32'h1);
        ticks(2);
        rd(A_VAL, v); check("R9 restart", v, 32'd6);
        wr(A_VAL, 32'd8);
        rd(A_VAL, v); check("R9 mid reload", v, 32'd8);
        wr(A_CTRL, 32'h13);
        check("R7 ack with ie", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(A_VAL, 32'd50, 1'b1);
        rd(A_VAL, v); check("R10 write beats tick", v, 32'd50);
        wr(A_VAL, 32'd3);
        ticks(2);
        wr(A_CTRL, 32'h13, 1'b1);
        check("R7 expiry beats clear", {31'b0, irq}, 32'h1);
        rd(A_VAL, v); check("R5 zero after collision", v, 32'd0);
        wr(A_CTRL, 32'h11);
    endtask

    task automatic t_other();
        logic [31:0] v;
        wr(A_VAL, 32'hFFFF_FFFF);
        rd(A_VAL, v); check("R3 max load", v, 32'hFFFF_FFFF);
        ticks(1);
        rd(A_VAL, v); check("R4 max step", v, 32'hFFFF_FFFE);
        wr(A_CTRL, 32'h0);
        wr(8'h48, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0000_0013);
        rd(A_CTRL, v); check("R11 ctrl untouched", v, 32'h0);
        rd(A_VAL, v);  check("R11 value untouched", v, 32'hFFFF_FFFE);
        rd(8'h48, v);  check("R11 unmapped read", v, 32'h0);
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_countdown();
        t_ack();
        t_mask();
        t_stop();
        t_reload();
        t_collide();
        t_other();
        done = 1'b1;
        report();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

endmodule